// File: doc/BRIEF.md
# Region-Policy Data Cache Controller

The block is a direct-mapped data cache controller that sits between a processor load/store port and a system memory port. The cache holds 16 sets of 8-word lines of 32-bit words. Each access comes with two attribute bits for its address region. One bit says whether the region may be cached. The other chooses write-through or write-back. Two configuration bits stop line allocation on a load miss or on a store miss. For every access the controller chooses one of four actions: serve it from the cache, allocate a line, go straight to memory, or write both the cache and memory.

The memory port carries single-word transfers and 8-beat line bursts. A burst writes out a dirty victim or fills a line. A separate flush command names a set. It writes that line back only if the line is valid and dirty, and then marks it clean. Requests are level-held: the processor keeps `cpu_req` and its operands stable until `cpu_ack`, and the flush requester holds `flush_req` until `flush_ack`. Addresses are word addresses. Bits [2:0] select the word, bits [6:3] select the set, and the upper bits are the tag.

Top module: `dcache_ctl`

## Requirements
- R1: A load hit in a cacheable region is acknowledged in the cycle it is presented, with the cached word on `cpu_rdata` and no memory transfer.
- R2: A store hit to a write-back region is acknowledged in the same cycle. It updates only the cached word, marks the line dirty, and causes no memory transfer.
- R3: A store hit to a write-through region updates the cached word and makes one single-word memory write. The store is acknowledged on that write's `mem_ack`.
- R4: A store miss to a write-through region makes one single-word memory write and allocates no line.
- R5: A non-cacheable access ignores the write-policy bit and the cache contents. It makes exactly one single-word transfer (`mem_burst`=0) and allocates nothing.
- R6: A load miss in a cacheable region with load-without-allocate clear fetches the whole line with an 8-beat burst starting at word 0. The load is acknowledged, from the filled line, in the cycle after the last beat.
- R7: With load-without-allocate set, a cacheable load miss makes one single-word read and allocates nothing.
- R8: With store-without-allocate set, a store miss to a write-back region makes one single-word memory write and allocates nothing.
- R9: With store-without-allocate set, a store hit to a write-back region still updates only the cache and marks the line dirty, with no memory write.
- R10: When an allocating miss displaces a valid dirty line, all 8 words of the victim are written to memory at the victim's address before the first beat of the refill read.
- R11: A flush of a valid dirty set writes the 8 words back and then clears the dirty bit, with `flush_ack` on the last beat. A flush of a clean or invalid set is acknowledged in the cycle it is presented and causes no memory transfer.
- R12: Burst beats use consecutive word addresses, and `mem_req` stays high between them.
- R13: `cpu_ack` is asserted only while `cpu_req` is high. After reset, neither `cpu_ack` nor `mem_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_cacheable | input | 1 | Region may be cached |
| cpu_wthru | input | 1 | Region write policy: 1 = write-through, 0 = write-back |
| cfg_load_noalloc | input | 1 | Load misses do not allocate |
| cfg_store_noalloc | input | 1 | Store misses do not allocate |
| cpu_ack | output | 1 | Access complete this cycle |
| cpu_rdata | output | DW | Load data, valid with `cpu_ack` |
| flush_req | input | 1 | Flush request, held until `flush_ack` |
| flush_set | input | log2(SETS) | Set to flush |
| flush_ack | output | 1 | Flush complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_burst | output | 1 | Transfer is part of an 8-beat line burst |
| mem_addr | output | AW | Word address of the current beat |
| mem_wdata | output | DW | Write data of the current beat |
| mem_ack | input | 1 | Current beat accepted / read data valid |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The bench memory accepts every beat in the cycle it is requested. Under that condition each response has a fixed latency:
- A hit, and a flush of a clean or invalid set, is acknowledged in the same cycle.
- A single-word transfer is acknowledged one cycle after the request.
- A clean refill is acknowledged after nine cycles, and a refill behind a dirty victim after seventeen.
- A dirty flush is acknowledged on its eighth cycle.

For every access, the reference model predicts this latency, the beat list (direction, address and data) and the read data. The bench counts cycles from presentation to acknowledge and compares the count, the logged beats and the returned word against those predictions.

// File: rtl/dcache_ctl.sv
module dcache_ctl #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int LINE_W = 8,
  parameter int SETS   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [DW-1:0]           cpu_wdata,
  input  logic                    cpu_cacheable,
  input  logic                    cpu_wthru,
  input  logic                    cfg_load_noalloc,
  input  logic                    cfg_store_noalloc,
  output logic                    cpu_ack,
  output logic [DW-1:0]           cpu_rdata,
  input  logic                    flush_req,
  input  logic [$clog2(SETS)-1:0] flush_set,
  output logic                    flush_ack,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_burst,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic                    mem_ack,
  input  logic [DW-1:0]           mem_rdata
);
  localparam int OFFB = $clog2(LINE_W);
  localparam int IDXB = $clog2(SETS);
  localparam int TAGB = AW - OFFB - IDXB;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_SINGLE} st_t;

  st_t                st;
  logic [TAGB-1:0]    tags [SETS];
  logic [DW-1:0]      data [SETS*LINE_W];
  logic [SETS-1:0]    valid, dirty;
  logic [OFFB-1:0]    beat;
  logic [IDXB-1:0]    widx;
  logic               flushing;

  wire [OFFB-1:0] off  = cpu_addr[OFFB-1:0];
  wire [IDXB-1:0] idx  = cpu_addr[OFFB +: IDXB];
  wire [TAGB-1:0] tag  = cpu_addr[AW-1 -: TAGB];
  wire idle     = (st == S_IDLE);
  wire take_cpu = idle & cpu_req & ~flush_req;
  wire hit      = cpu_cacheable & valid[idx] & (tags[idx] == tag);
  wire alloc    = cpu_we ? (~cpu_wthru & ~cfg_store_noalloc) : ~cfg_load_noalloc;
  wire last     = mem_ack & (beat == {OFFB{1'b1}});
  wire fl_dirty = valid[flush_set] & dirty[flush_set];

  assign cpu_ack   = (take_cpu & hit & ~(cpu_we & cpu_wthru)) | ((st == S_SINGLE) & mem_ack);
  assign cpu_rdata = (st == S_SINGLE) ? mem_rdata : data[{idx, off}];
  assign flush_ack = (idle & flush_req & ~fl_dirty) | ((st == S_EVICT) & flushing & last);
  assign mem_req   = ~idle;
  assign mem_we    = (st == S_EVICT) | ((st == S_SINGLE) & cpu_we);
  assign mem_burst = (st == S_EVICT) | (st == S_FILL);
  assign mem_wdata = (st == S_EVICT) ? data[{widx, beat}] : cpu_wdata;

  always_comb begin
    case (st)
      S_EVICT: mem_addr = {tags[widx], widx, beat};
      S_FILL:  mem_addr = {tag, idx, beat};
      default: mem_addr = cpu_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      valid    <= '0;
      dirty    <= '0;
      beat     <= '0;
      widx     <= '0;
      flushing <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          beat <= '0;
          if (flush_req) begin
            if (fl_dirty) begin
              widx     <= flush_set;
              flushing <= 1'b1;
              st       <= S_EVICT;
            end
          end else if (cpu_req) begin
            if (hit) begin
              if (cpu_we && cpu_wthru) st <= S_SINGLE;
              else if (cpu_we)         dirty[idx] <= 1'b1;
            end else if (cpu_cacheable && alloc) begin
              widx     <= idx;
              flushing <= 1'b0;
              st       <= (valid[idx] && dirty[idx]) ? S_EVICT : S_FILL;
            end else begin
              st <= S_SINGLE;
            end
          end
        end
        S_EVICT: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last) begin
            dirty[widx] <= 1'b0;
            st          <= flushing ? S_IDLE : S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last) begin
            valid[idx] <= 1'b1;
            dirty[idx] <= 1'b0;
            st         <= S_IDLE;
          end
        end
        default: if (mem_ack) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_cpu && hit && cpu_we) data[{idx, off}] <= cpu_wdata;
    if (st == S_FILL && mem_ack) begin
      data[{idx, beat}] <= mem_rdata;
      if (last) tags[idx] <= tag;
    end
  end
endmodule

module dcache_ctl_chk #(
  parameter int AW   = 12,
  parameter int SETS = 16,
  parameter int IDXB = 4,
  parameter int OFFB = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            cpu_ack,
  input logic            flush_req,
  input logic            flush_ack,
  input logic [IDXB-1:0] flush_set,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic            mem_burst,
  input logic [AW-1:0]   mem_addr,
  input logic [SETS-1:0] dirty
);
  assert_ack_needs_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req);

  assert_flush_ack_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ack |-> flush_req);

  assert_flush_leaves_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ack |=> !dirty[$past(flush_set)]);

  assert_burst_sequential_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_burst && mem_addr[OFFB-1:0] != {OFFB{1'b1}})
    |=> (mem_req && mem_burst && mem_addr == $past(mem_addr) + AW'(1)));

  assert_victim_then_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_burst && mem_we && mem_addr[OFFB-1:0] == {OFFB{1'b1}} && !flush_ack)
    |=> (mem_req && mem_burst && !mem_we && mem_addr[OFFB-1:0] == '0));

  assert_single_one_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_burst) |=> !mem_req);
endmodule

bind dcache_ctl dcache_ctl_chk #(.AW(AW), .SETS(SETS), .IDXB(IDXB), .OFFB(OFFB)) u_chk (.*);

// File: tb/dcache_ctl_tb.sv
module dcache_ctl_tb;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_cacheable = 0, cpu_wthru = 0;
  logic cfg_load_noalloc = 0, cfg_store_noalloc = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic flush_req = 0;
  logic [3:0] flush_set = '0;
  logic cpu_ack, flush_ack, mem_req, mem_we, mem_burst, mem_ack;
  logic [DW-1:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] refmem [1<<AW];
  bit mv [16];
  bit md [16];
  int mt [16];
  logic [DW-1:0] mdata [128];
  int exp_a[$], exp_w[$], act_a[$], act_w[$];
  logic [DW-1:0] exp_d[$], act_d[$];

  always #5 clk = ~clk;

  dcache_ctl u_dut (.*);

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_req) begin
    act_a.push_back(int'(mem_addr));
    act_w.push_back(int'(mem_we));
    act_d.push_back(mem_we ? mem_wdata : mem[mem_addr]);
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string rq, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic void push(input int w, input int a, input logic [DW-1:0] d);
    exp_w.push_back(w); exp_a.push_back(a); exp_d.push_back(d);
    if (w != 0) refmem[a] = d;
  endfunction

  task automatic compare_traffic(input string rq);
    bit ok = (act_a.size() == exp_a.size());
    int bad = -1;
    if (ok) foreach (exp_a[i])
      if (bad < 0 && (act_a[i] != exp_a[i] || act_w[i] != exp_w[i] || act_d[i] !== exp_d[i])) bad = i;
    if (!ok) check(0, rq, "beat count", act_a.size(), exp_a.size());
    else if (bad >= 0) check(0, rq, "beat addr", act_a[bad], exp_a[bad]);
    else check(1, rq, "traffic", 0, 0);
  endtask

  task automatic access(input bit we, input int a, input logic [DW-1:0] wd, input bit c, input bit wt,
                        input bit lna, input bit sna, input string rq);
    int idx = (a >> 3) & 15, tg = a >> 7, lat = 0, n = 0;
    bit hit = c && mv[idx] && mt[idx] == tg;
    logic [DW-1:0] erd = 'x;
    exp_a = {}; exp_w = {}; exp_d = {};
    if (!c || (!hit && (we ? (wt || sna) : lna))) begin
      lat = 1;
      if (we) push(1, a, wd); else begin push(0, a, refmem[a]); erd = refmem[a]; end
    end else begin
      if (!hit) begin
        lat = 9;
        if (mv[idx] && md[idx]) begin
          lat = 17;
          for (int b = 0; b < 8; b++) push(1, (mt[idx] << 7) | (idx << 3) | b, mdata[idx*8+b]);
        end
        for (int b = 0; b < 8; b++) begin
          push(0, (a & ~7) + b, refmem[(a & ~7) + b]);
          mdata[idx*8+b] = refmem[(a & ~7) + b];
        end
        mv[idx] = 1; md[idx] = 0; mt[idx] = tg;
      end
      if (!we) erd = mdata[a & 127];
      else begin
        mdata[a & 127] = wd;
        if (wt) begin push(1, a, wd); lat = 1; end
        else md[idx] = 1;
      end
    end
    @(negedge clk);
    act_a = {}; act_w = {}; act_d = {};
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd; cpu_cacheable = c; cpu_wthru = wt;
    cfg_load_noalloc = lna; cfg_store_noalloc = sna;
    #1;
    while (!cpu_ack && n < 100) begin @(negedge clk); #1; n++; end
    check(n == lat, rq, "latency", n, lat);
    if (!we) check(cpu_rdata === erd, rq, "rdata", cpu_rdata, erd);
    @(negedge clk);
    cpu_req = 0;
    compare_traffic(rq);
  endtask

  task automatic flush(input int s, input string rq);
    int lat = 0, n = 0;
    exp_a = {}; exp_w = {}; exp_d = {};
    if (mv[s] && md[s]) begin
      lat = 8;
      for (int b = 0; b < 8; b++) push(1, (mt[s] << 7) | (s << 3) | b, mdata[s*8+b]);
      md[s] = 0;
    end
    @(negedge clk);
    act_a = {}; act_w = {}; act_d = {};
    flush_req = 1; flush_set = 4'(s);
    #1;
    while (!flush_ack && n < 100) begin @(negedge clk); #1; n++; end
    check(n == lat, rq, "flush latency", n, lat);
    @(negedge clk);
    flush_req = 0;
    compare_traffic(rq);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = 32'hA500_0000 | i; refmem[i] = mem[i]; end
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!cpu_ack && !mem_req, "R13", "reset idle", {cpu_ack, mem_req}, 0);

    access(0, 'h010, 0, 1, 0, 0, 0, "R6");
    access(0, 'h013, 0, 1, 0, 0, 0, "R1");
    access(1, 'h012, 32'h1111_2222, 1, 0, 0, 0, "R2");
    access(0, 'h012, 0, 1, 0, 0, 0, "R2");
    access(0, 'h810, 0, 1, 0, 0, 0, "R10");
    access(1, 'h811, 32'h3333_4444, 1, 1, 0, 0, "R3");
    access(1, 'h120, 32'h5555_6666, 1, 1, 0, 0, "R4");
    access(0, 'h120, 0, 1, 0, 0, 0, "R4");
    access(0, 'h811, 0, 0, 1, 0, 0, "R5");
    access(1, 'h300, 32'h7777_8888, 0, 0, 0, 0, "R5");
    access(0, 'h400, 0, 1, 0, 1, 0, "R7");
    access(0, 'h400, 0, 1, 0, 0, 0, "R7");
    access(1, 'h500, 32'h9999_AAAA, 1, 0, 0, 1, "R8");
    access(0, 'h500, 0, 0, 0, 0, 0, "R8");
    access(1, 'h811, 32'hBBBB_CCCC, 1, 0, 0, 1, "R9");
    flush(2, "R11");
    flush(2, "R11");
    flush(15, "R11");
    access(0, 'h811, 0, 0, 0, 0, 0, "R11");
    for (int k = 0; k < 150; k++) begin
      int a = $urandom_range(0, 511) | ($urandom_range(0, 3) << 9);
      if ($urandom_range(0, 9) == 0) flush($urandom_range(0, 15), "R11");
      else access($urandom_range(0, 1), a, $urandom, $urandom_range(0, 5) != 0,
                  $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 3) == 0, "R12");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule